// File: doc/BRIEF.md
# Charge-Retaining Net Resolver with Decay

This block is a clocked, synthesizable stand-in for a shared net that keeps its charge. Several drivers can each drive any bit of the net. Every driver has a per-bit active flag, a per-bit data bit and one strength code. On each clock edge the block resolves the active drivers against each other and against the charge stored on the net. It registers three things per bit: the resulting value (0, 1 or unknown), the strength it presents, and a state code.

A bit remembers the last value it was driven to once every driver has let go of it. The stored charge has a rank set by a parameter. A later driver overwrites the charge only if that driver is ranked higher than the charge. An optional counter, measured in clock cycles, turns a held value into unknown if no driver comes back within the window. Every bit of the net is fully independent: it has its own stored value, its own state and its own counter.

Top module: `charge_net_resolver`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit enters state never-driven (code 0) with value X (code 2'b10) at the capacitor strength, and its decay counter is cleared.
- R2: When at least one driver is active on a bit and the stored charge does not win, the next cycle shows the resolved driver value at the top active strength. The state becomes driven (code 1) and the value is stored. Value codes: 0 = 2'b00, 1 = 2'b01, X = 2'b10.
- R3: When every driver releases a bit that was driven or holding, the next cycle shows the stored value at the capacitor strength, with state holding (code 2).
- R4: A bit stays never-driven, showing X at the capacitor strength, until its first activation. It never returns to never-driven except through reset.
- R5: While a bit's charge is valid (state driven or holding), an active driver replaces the stored value only if its rank is strictly above `CAP_RANK`. Otherwise the stored value is shown at the capacitor strength with state driven. Strength codes are: small 1, medium 2, weak 3, large 4, pull 5, strong 6.
- R6: After a bit has shown holding for `DECAY_CYCLES` consecutive cycles, it shows X at the capacitor strength with state decayed (code 3). A decayed charge no longer competes with drivers. With `DECAY_CYCLES` = 0, a held value lasts indefinitely.
- R7: Any activation of a holding or decayed bit clears its decay counter and returns it to driven. A later release therefore starts a fresh full window.
- R8: Among active drivers the highest rank wins. If drivers tied at the top rank disagree, the result is X at that rank.
- R9: Each bit resolves from its own active and data bits only. It has its own state and its own counter.
- R10: Outputs are registered and respond exactly one clock cycle after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| drv_act | input | NDRV*WIDTH | Per-driver, per-bit active flags; driver i occupies bits [i*WIDTH +: WIDTH] |
| drv_data | input | NDRV*WIDTH | Per-driver data bits, laid out like drv_act |
| drv_str | input | NDRV*3 | Strength code of each driver; driver i at [i*3 +: 3] |
| net_val | output | 2*WIDTH | Per-bit value code; bit b at [b*2 +: 2] |
| net_str | output | 3*WIDTH | Per-bit presented strength; bit b at [b*3 +: 3] |
| net_state | output | 2*WIDTH | Per-bit state code; bit b at [b*2 +: 2] |

## Verification
The hardest situation to reach is the exact end of the decay window on a bit whose counter was cleared part-way through by a short activation. Reaching it needs a long, uninterrupted quiet stretch on that single bit while its neighbours stay busy. The stimulus alternates busy phases with quiet phases in which drivers are rarely active. It also runs directed sequences that hold a bit idle across the window, then re-activate it and idle it again. A second instance with a large capacitor and no decay runs on the same inputs, so the weak-versus-large and pull-versus-large contests are seen alongside the medium case.

// File: rtl/cnr_pkg.sv
package cnr_pkg;
  localparam int STR_W = 3;

  localparam logic [1:0] V_ZERO = 2'b00;
  localparam logic [1:0] V_ONE  = 2'b01;
  localparam logic [1:0] V_X    = 2'b10;

  localparam logic [2:0] RK_SMALL  = 3'd1;
  localparam logic [2:0] RK_MEDIUM = 3'd2;
  localparam logic [2:0] RK_WEAK   = 3'd3;
  localparam logic [2:0] RK_LARGE  = 3'd4;
  localparam logic [2:0] RK_PULL   = 3'd5;
  localparam logic [2:0] RK_STRONG = 3'd6;

  typedef enum logic [1:0] {
    ST_NEVER  = 2'd0,
    ST_DRIVEN = 2'd1,
    ST_HOLD   = 2'd2,
    ST_DECAY  = 2'd3
  } net_state_e;
endpackage

// File: rtl/driver_resolver.sv
module driver_resolver
  import cnr_pkg::*;
#(
  parameter int NDRV = 3
) (
  input  logic [NDRV-1:0]       act,
  input  logic [NDRV-1:0]       data,
  input  logic [NDRV*STR_W-1:0] str,
  output logic                  any_act,
  output logic [STR_W-1:0]      top_rank,
  output logic [1:0]            top_val
);
  logic saw0, saw1;

  always_comb begin
    top_rank = '0;
    for (int i = 0; i < NDRV; i++) begin
      if (act[i] && (str[i*STR_W +: STR_W] > top_rank)) top_rank = str[i*STR_W +: STR_W];
    end
    saw0 = 1'b0;
    saw1 = 1'b0;
    for (int i = 0; i < NDRV; i++) begin
      if (act[i] && (str[i*STR_W +: STR_W] == top_rank)) begin
        if (data[i]) saw1 = 1'b1;
        else         saw0 = 1'b0 | 1'b1;
      end
    end
    any_act = |act;
    if (saw0 && saw1) top_val = V_X;
    else if (saw1)    top_val = V_ONE;
    else              top_val = V_ZERO;
  end
endmodule

// File: rtl/charge_cell.sv
module charge_cell
  import cnr_pkg::*;
#(
  parameter logic [2:0] CAP_RANK     = RK_MEDIUM,
  parameter int         DECAY_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_act,
  input  logic [STR_W-1:0] top_rank,
  input  logic [1:0]       top_val,
  output logic [1:0]       val_q,
  output logic [STR_W-1:0] str_q,
  output net_state_e       state_q
);
  localparam int CNT_W = (DECAY_CYCLES < 2) ? 1 : $clog2(DECAY_CYCLES);

  logic charge_ok, cap_wins, window_done;

  assign charge_ok = (state_q == ST_DRIVEN) || (state_q == ST_HOLD);
  assign cap_wins  = charge_ok && (top_rank <= CAP_RANK);

  generate
    if (DECAY_CYCLES == 0) begin : gen_nodecay
      assign window_done = 1'b0;
    end else begin : gen_decay
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || any_act || (state_q != ST_HOLD)) cnt_q <= '0;
        else                                         cnt_q <= cnt_q + 1'b1;
      end
      assign window_done = (state_q == ST_HOLD) && (cnt_q == CNT_W'(DECAY_CYCLES - 1));

      // R6
      cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cnt_q) < DECAY_CYCLES);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_NEVER;
      val_q   <= V_X;
      str_q   <= CAP_RANK;
    end else if (any_act) begin
      state_q <= ST_DRIVEN;
      if (cap_wins) begin
        str_q <= CAP_RANK;
      end else begin
        val_q <= top_val;
        str_q <= top_rank;
      end
    end else begin
      str_q <= CAP_RANK;
      case (state_q)
        ST_DRIVEN: state_q <= ST_HOLD;
        ST_HOLD: if (window_done) begin
          state_q <= ST_DECAY;
          val_q   <= V_X;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // R4
  never_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_NEVER) |=> (state_q != ST_NEVER));
  // R3
  hold_str_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> (str_q == CAP_RANK));
  // R7
  act_drives_chk: assert property (@(posedge clk) disable iff (rst)
    any_act |=> (state_q == ST_DRIVEN));
  // R5
  cap_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (any_act && (state_q == ST_HOLD) && (top_rank <= CAP_RANK)) |=> $stable(val_q));
  // R6
  decay_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!any_act && (state_q == ST_DECAY)) |=> ((state_q == ST_DECAY) && (val_q == V_X)));
endmodule

// File: rtl/charge_net_resolver.sv
module charge_net_resolver
  import cnr_pkg::*;
#(
  parameter int         WIDTH        = 4,
  parameter int         NDRV         = 3,
  parameter logic [2:0] CAP_RANK     = RK_MEDIUM,
  parameter int         DECAY_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NDRV*WIDTH-1:0] drv_act,
  input  logic [NDRV*WIDTH-1:0] drv_data,
  input  logic [NDRV*3-1:0]     drv_str,
  output logic [2*WIDTH-1:0]    net_val,
  output logic [3*WIDTH-1:0]    net_str,
  output logic [2*WIDTH-1:0]    net_state
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : gen_bit
      logic [NDRV-1:0]  b_act, b_data;
      logic             any_act;
      logic [STR_W-1:0] top_rank;
      logic [1:0]       top_val;
      net_state_e       st;

      for (genvar i = 0; i < NDRV; i++) begin : gen_tap
        assign b_act[i]  = drv_act[i*WIDTH + b];
        assign b_data[i] = drv_data[i*WIDTH + b];
      end

      driver_resolver #(.NDRV(NDRV)) i_res (
        .act(b_act), .data(b_data), .str(drv_str),
        .any_act(any_act), .top_rank(top_rank), .top_val(top_val)
      );

      charge_cell #(.CAP_RANK(CAP_RANK), .DECAY_CYCLES(DECAY_CYCLES)) i_cell (
        .clk(clk), .rst(rst), .any_act(any_act), .top_rank(top_rank), .top_val(top_val),
        .val_q(net_val[b*2 +: 2]), .str_q(net_str[b*3 +: 3]), .state_q(st)
      );
      assign net_state[b*2 +: 2] = st;
    end
  endgenerate
endmodule

// File: tb/test_charge_net_resolver.sv
module test_charge_net_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int N = 3;
  localparam int DEC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*W-1:0] drv_act = '0, drv_data = '0;
  logic [N*3-1:0] drv_str = '0;
  logic [2*W-1:0] val0, st0, val1, st1;
  logic [3*W-1:0] str0, str1;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: [instance][bit]
  int m_st[2][W], m_val[2][W], m_str[2][W], m_cnt[2][W];
  string m_tag[2][W];
  int cap[2];
  int dcy[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  charge_net_resolver #(.WIDTH(W), .NDRV(N), .CAP_RANK(3'd2), .DECAY_CYCLES(DEC)) i_charge_net_resolver (
    .clk(clk), .rst(rst), .drv_act(drv_act), .drv_data(drv_data), .drv_str(drv_str),
    .net_val(val0), .net_str(str0), .net_state(st0));

  charge_net_resolver #(.WIDTH(W), .NDRV(N), .CAP_RANK(3'd4), .DECAY_CYCLES(0)) i_charge_net_resolver_lg (
    .clk(clk), .rst(rst), .drv_act(drv_act), .drv_data(drv_data), .drv_str(drv_str),
    .net_val(val1), .net_str(str1), .net_state(st1));

  // Advance the model by one clock edge from the present inputs.
  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < W; b++) begin
        int top, v, any;
        bit s0, s1, ok;
        top = 0; any = 0; s0 = 0; s1 = 0;
        for (int i = 0; i < N; i++)
          if (drv_act[i*W+b]) begin
            any = 1;
            if (int'(drv_str[i*3 +: 3]) > top) top = int'(drv_str[i*3 +: 3]);
          end
        for (int i = 0; i < N; i++)
          if (drv_act[i*W+b] && int'(drv_str[i*3 +: 3]) == top) begin
            if (drv_data[i*W+b]) s1 = 1; else s0 = 1;
          end
        v = (s0 && s1) ? 2 : (s1 ? 1 : 0);
        ok = (m_st[k][b] == 1) || (m_st[k][b] == 2);
        if (rst) begin
          m_st[k][b] = 0; m_val[k][b] = 2; m_str[k][b] = cap[k]; m_cnt[k][b] = 0; m_tag[k][b] = "R1";
        end else if (any) begin
          if (ok && top <= cap[k]) begin
            m_str[k][b] = cap[k]; m_tag[k][b] = "R5";
          end else begin
            m_val[k][b] = v; m_str[k][b] = top;
            m_tag[k][b] = (s0 && s1) ? "R8" : ((m_st[k][b] >= 2) ? "R7" : "R2");
          end
          m_st[k][b] = 1; m_cnt[k][b] = 0;
        end else begin
          m_str[k][b] = cap[k];
          if (m_st[k][b] == 0) m_tag[k][b] = "R4";
          else if (m_st[k][b] == 1) begin m_st[k][b] = 2; m_cnt[k][b] = 0; m_tag[k][b] = "R3"; end
          else if (m_st[k][b] == 2) begin
            if (dcy[k] != 0 && m_cnt[k][b] == dcy[k]-1) begin
              m_st[k][b] = 3; m_val[k][b] = 2; m_tag[k][b] = "R6";
            end else begin
              if (dcy[k] != 0) m_cnt[k][b]++;
              m_tag[k][b] = (dcy[k] == 0) ? "R6" : "R3";
            end
          end else m_tag[k][b] = "R6";
        end
      end
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      for (int b = 0; b < W; b++) begin
        int av, as, at;
        av = (k == 0) ? int'(val0[b*2 +: 2]) : int'(val1[b*2 +: 2]);
        as = (k == 0) ? int'(str0[b*3 +: 3]) : int'(str1[b*3 +: 3]);
        at = (k == 0) ? int'(st0[b*2 +: 2])  : int'(st1[b*2 +: 2]);
        checks++;
        if (av != m_val[k][b] || as != m_str[k][b] || at != m_st[k][b]) begin
          errors++;
          $display("FAIL %s (R9 R10) inst %0d bit %0d: val/str/state actual %0d/%0d/%0d expected %0d/%0d/%0d",
                   m_tag[k][b], k, b, av, as, at, m_val[k][b], m_str[k][b], m_st[k][b]);
        end
      end
    end
  endtask

  // Drive inputs at the falling edge, then check just after the next rising edge.
  task automatic cyc(input logic [N*W-1:0] a, input logic [N*W-1:0] d, input logic [N*3-1:0] s);
    @(negedge clk);
    drv_act = a; drv_data = d; drv_str = s;
    model_step();
    @(posedge clk);
    #1;
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*3-1:0] s_sw, s_pw, s_ss;
    cap[0] = 2; cap[1] = 4; dcy[0] = DEC; dcy[1] = 0;
    s_sw = {3'd1, 3'd3, 3'd6};   // drv0 strong, drv1 weak, drv2 small
    s_pw = {3'd1, 3'd5, 3'd6};   // drv1 pull
    s_ss = {3'd1, 3'd6, 3'd6};   // drv0 and drv1 both strong
    // R1 reset state
    repeat (3) cyc('0, '0, s_sw);
    rst = 1'b0;
    // R4 no driver yet
    repeat (2) cyc('0, '0, s_sw);
    // R2 strong drives 1 on all bits
    cyc(12'h00F, 12'h00F, s_sw);
    // R5 weak drives 0 with strong released: wins on medium, loses on large
    cyc(12'h0F0, 12'h000, s_sw);
    // R3 release
    cyc('0, '0, s_sw);
    // pull drives 1 on bits 0 and 2: beats large (R5), R9 per bit
    cyc(12'h050, 12'h0F0, s_pw);
    // R8 tie of two strong drivers with opposite values on bits 1 and 3
    cyc(12'h0AA, 12'h00A, s_ss);
    // R6 long release: decay on medium instance, no decay on large
    repeat (12) cyc('0, '0, s_sw);
    // R7 re-activate bit 0 only, then release past the window again
    cyc(12'h001, 12'h001, s_sw);
    repeat (4) cyc('0, '0, s_sw);
    cyc(12'h001, 12'h000, s_sw);
    repeat (11) cyc('0, '0, s_sw);
    // R1 reset in mid-operation
    rst = 1'b1; cyc(12'h00F, 12'h00F, s_sw); rst = 1'b0;
    // random phases
    void'($urandom(32'hC0FFEE));
    for (int ph = 0; ph < 200; ph++) begin
      int busy;
      busy = ph % 2;
      for (int c = 0; c < 20; c++) begin
        logic [N*W-1:0] a, d;
        logic [N*3-1:0] s;
        for (int j = 0; j < N*W; j++) begin
          a[j] = busy ? ($urandom % 3 == 0) : ($urandom % 40 == 0);
          d[j] = $urandom % 2;
        end
        for (int i = 0; i < N; i++) s[i*3 +: 3] = 3'(1 + $urandom % 6);
        cyc(a, d, s);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule